// File: doc/BRIEF.md
# Two-Wire Register Target with Ancillary Data Window

This block is the control-port target of a streaming audio decoder. A host controller on a two-wire serial bus (I2C) reads and writes a map of 256 byte-wide registers. It uses the usual transfers: single-byte writes, multi-byte writes with address auto-increment, reads from the current address, reads from a random address, and sequential reads. Both bus lines are sampled against the system clock. The target pulls SDA low through an enable output and never holds SCL.

The decoder core sits on the other side of the block. It reads any register through a parallel lookup port, and it sees the command byte, a run level and a one-cycle soft-reset pulse. A five-byte ancillary window holds data that the core supplies. The host asks for fresh data by setting a request bit. The core answers with a load strobe, which fills the window and clears the request. A write of any value to the soft-reset register puts the core back in idle. It also clears the command and request registers.

Top module: `i2c_anc_regslave`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 7'h43); bit 0 is the direction (1 = read). Any other address gets no acknowledge, and the target ignores the bus until the next start condition.
- R2: In a write transfer, the first byte after the address loads the register pointer. Each later byte is stored at the pointer and then advances it, and the stored value appears on `core_data_o` when `core_addr_i` selects it.
- R3: A read transfer returns the register at the pointer. The pointer persists across transfers, so a current-address read continues from where the previous access ended. A random read is a pointer write, a repeated start, then a read.
- R4: During a read, every byte the host acknowledges advances the pointer and the next register is sent. A not-acknowledged byte ends the read.
- R5: The pointer wraps from 0xFF to 0x00 when it advances.
- R6: Addresses 0x59 to 0x5D form the ancillary window. Host writes to them, and to the soft-reset address 0x10, are acknowledged but leave the stored registers unchanged.
- R7: Bit 0 of the request register (0x14) drives `anc_req_o`. A pulse on `anc_load_i` stores byte k of `anc_data_i` (bits 8k+7..8k) at address 0x59+k and clears the request register on the same clock edge.
- R8: A host write of any value to 0x10 pulses `soft_rst_o` high for one cycle. It clears the command (0x13), request (0x14) and run (0x72) registers and leaves every other register unchanged. Reads of 0x10 return 0x00.
- R9: Bit 0 of the run register (0x72) drives `run_o`, and `cmd_o` shows register 0x13.
- R10: After reset, every register reads 0x00 and SDA is released.
- R11: The target changes its SDA enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| core_addr_i | input | 8 | Core lookup address |
| core_data_o | output | 8 | Register value at `core_addr_i` |
| cmd_o | output | 8 | Command register contents |
| run_o | output | 1 | Core run level |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |
| anc_req_o | output | 1 | Ancillary refill request |
| anc_load_i | input | 1 | Core strobe that loads the window |
| anc_data_i | input | 40 | Five window bytes, byte 0 in the low bits |

## Verification
The bench drives the pointer through the 0xFF boundary. A design whose pointer saturates, or skips the wrap, returns the same register twice. It sends a foreign device address followed by a data byte. A target that compared the address loosely would acknowledge it and corrupt a register. The bench also writes into the read-only window and into the soft-reset address, and then checks through the lookup port that the stored values did not change. It checks that a load strobe clears the request, and that a soft reset clears the command, request and run registers while other registers keep their values, so a bank with the wrong clear set shows up at once.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } xfer_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_e;
endpackage

// File: rtl/i2cs_rst_sync.sv
module i2cs_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic scl_prev_q, sda_prev_q;
  logic scl_s;

  // synchronizer chain, one flop per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe_q[0] <= 1'b1;
          sda_pipe_q[0] <= 1'b1;
        end else begin
          scl_pipe_q[0] <= scl_i;
          sda_pipe_q[0] <= sda_i;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe_q[g] <= 1'b1;
          sda_pipe_q[g] <= 1'b1;
        end else begin
          scl_pipe_q[g] <= scl_pipe_q[g-1];
          sda_pipe_q[g] <= sda_pipe_q[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe_q[STAGES-1];
  assign sda_s = sda_pipe_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2c_reg_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'h43
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] ptr,
  output logic          wr_stb,
  output logic [7:0]    wdata,
  output logic          sda_oe
);
  xfer_st_e  state_q, state_d;
  rx_phase_e phase_q, phase_d;
  logic [2:0]    cnt_q, cnt_d;
  logic          got8_q, got8_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    tx_q, tx_d;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic          oe_q, oe_d;
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    got8_d  = got8_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    ptr_d   = ptr_q;
    wr_stb  = 1'b0;
    if (start_det) begin
      state_d = ST_RX;
      phase_d = PH_ADDR;
      cnt_d   = 3'd0;
      got8_d  = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d   = {sh_q[6:0], sda_s};
            cnt_d  = cnt_q + 3'd1;
            got8_d = (cnt_q == 3'd7);
          end else if (scl_fall && got8_q) begin
            got8_d = 1'b0;
            case (phase_q)
              PH_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_d    = sh_q[0];
                  oe_d    = 1'b1;
                  state_d = ST_ACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              PH_PTR: begin
                ptr_d   = sh_q[AW-1:0];
                phase_d = PH_DATA;
                oe_d    = 1'b1;
                state_d = ST_ACK;
              end
              default: begin
                wr_stb  = 1'b1;
                ptr_d   = ptr_q + 1'b1;
                oe_d    = 1'b1;
                state_d = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = 3'd0;
            if (phase_q == PH_ADDR && rw_q) begin
              tx_d    = rdata;
              oe_d    = ~rdata[7];
              state_d = ST_TX;
            end else begin
              if (phase_q == PH_ADDR) phase_d = PH_PTR;
              oe_d    = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RACK;
            end else begin
              tx_d  = {tx_q[6:0], 1'b0};
              oe_d  = ~tx_q[6];
              cnt_d = cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d    = rdata;
              oe_d    = ~rdata[7];
              cnt_d   = 3'd0;
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      cnt_q   <= 3'd0;
      got8_q  <= 1'b0;
      sh_q    <= 8'h00;
      tx_q    <= 8'h00;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      got8_q  <= got8_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
      ptr_q   <= ptr_d;
    end
  end

  assign ptr    = ptr_q;
  assign wdata  = sh_q;
  assign sda_oe = oe_q;
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
  parameter int            AW        = 8,
  parameter int            ANC_LEN   = 5,
  parameter logic [AW-1:0] ANC_BASE  = 8'h59,
  parameter logic [AW-1:0] SRST_ADDR = 8'h10,
  parameter logic [AW-1:0] CMD_ADDR  = 8'h13,
  parameter logic [AW-1:0] REQ_ADDR  = 8'h14,
  parameter logic [AW-1:0] RUN_ADDR  = 8'h72
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [AW-1:0]        host_addr,
  output logic [7:0]           host_rdata,
  input  logic [AW-1:0]        core_addr,
  output logic [7:0]           core_rdata,
  input  logic                 anc_load,
  input  logic [ANC_LEN*8-1:0] anc_data,
  output logic [7:0]           cmd,
  output logic                 run,
  output logic                 anc_req,
  output logic                 soft_rst
);
  localparam int NREG = 2 ** AW;

  logic [7:0]  regs_q [NREG];
  logic [AW:0] win_off;
  logic        in_win, srst_hit, wr_keep;
  logic        srst_q;

  assign win_off  = {1'b0, wr_addr} - {1'b0, ANC_BASE};
  assign in_win   = !win_off[AW] && (win_off < (AW+1)'(ANC_LEN));
  assign srst_hit = wr_stb && (wr_addr == SRST_ADDR);
  assign wr_keep  = wr_stb && !in_win && (wr_addr != SRST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
    end else begin
      if (wr_keep) regs_q[wr_addr] <= wr_data;
      if (srst_hit) begin
        regs_q[CMD_ADDR] <= 8'h00;
        regs_q[REQ_ADDR] <= 8'h00;
        regs_q[RUN_ADDR] <= 8'h00;
      end
      if (anc_load) begin
        for (int k = 0; k < ANC_LEN; k++)
          regs_q[ANC_BASE + AW'(k)] <= anc_data[8*k +: 8];
        regs_q[REQ_ADDR] <= 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= srst_hit;
  end

  assign host_rdata = (host_addr == SRST_ADDR) ? 8'h00 : regs_q[host_addr];
  assign core_rdata = (core_addr == SRST_ADDR) ? 8'h00 : regs_q[core_addr];
  assign cmd        = regs_q[CMD_ADDR];
  assign run        = regs_q[RUN_ADDR][0];
  assign anc_req    = regs_q[REQ_ADDR][0];
  assign soft_rst   = srst_q;
endmodule

// File: rtl/i2c_anc_regslave.sv
module i2c_anc_regslave #(
  parameter int         AW          = 8,
  parameter int         ANC_LEN     = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h43
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [AW-1:0]        core_addr_i,
  output logic [7:0]           core_data_o,
  output logic [7:0]           cmd_o,
  output logic                 run_o,
  output logic                 soft_rst_o,
  output logic                 anc_req_o,
  input  logic                 anc_load_i,
  input  logic [ANC_LEN*8-1:0] anc_data_i
);
  logic          rst_n_int;
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr;
  logic          wr_stb;
  logic [7:0]    wdata, rdata;

  i2cs_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  i2cs_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_xfer_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rdata     (rdata),
    .ptr       (ptr),
    .wr_stb    (wr_stb),
    .wdata     (wdata),
    .sda_oe    (sda_oe_o)
  );

  i2cs_regbank #(.AW(AW), .ANC_LEN(ANC_LEN)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_stb     (wr_stb),
    .wr_addr    (ptr),
    .wr_data    (wdata),
    .host_addr  (ptr),
    .host_rdata (rdata),
    .core_addr  (core_addr_i),
    .core_rdata (core_data_o),
    .anc_load   (anc_load_i),
    .anc_data   (anc_data_i),
    .cmd        (cmd_o),
    .run        (run_o),
    .anc_req    (anc_req_o),
    .soft_rst   (soft_rst_o)
  );
endmodule

// File: rtl/i2c_anc_regslave_chk.sv
module i2c_anc_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       soft_rst_o,
  input logic       run_o,
  input logic       anc_req_o,
  input logic       anc_load_i,
  input logic [7:0] cmd_o
);
  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R8
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (!run_o && !anc_req_o && cmd_o == 8'h00));

  // R8
  srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  // R7
  anc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anc_load_i |=> !anc_req_o);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !sda_oe_o);
endmodule

bind i2c_anc_regslave i2c_anc_regslave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .soft_rst_o (soft_rst_o),
  .run_o      (run_o),
  .anc_req_o  (anc_req_o),
  .anc_load_i (anc_load_i),
  .cmd_o      (cmd_o)
);

// File: tb/sim_i2c_anc_regslave.sv
`timescale 1ns/1ps
module sim_i2c_anc_regslave;
  localparam int HP = 10;
  localparam logic [6:0] DEV = 7'h43;
  // {register address, data}
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h133C, 16'h40FF,
                                      16'h7201, 16'h7E80, 16'hC35A};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic [7:0] core_addr = 8'h00;
  logic anc_load = 1'b0;
  logic [39:0] anc_data = 40'h0;
  logic sda_oe, run, srst, anc_req;
  logic [7:0] core_data, cmd;
  wire sda_bus = sda_h & ~sda_oe;
  int n_chk = 0, n_fail = 0, srst_cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_anc_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .core_addr_i(core_addr), .core_data_o(core_data),
    .cmd_o(cmd), .run_o(run), .soft_rst_o(srst), .anc_req_o(anc_req),
    .anc_load_i(anc_load), .anc_data_i(anc_data)
  );

  always @(negedge clk) if (srst) srst_cycles++;

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_h = 1'b1; hp(); scl_h = 1'b1; hp(); sda_h = 1'b0; hp(); scl_h = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    sda_h = 1'b0; hp(); scl_h = 1'b1; hp(); sda_h = 1'b1; hp();
  endtask

  task automatic put_bit(input logic b);
    sda_h = b; hp(); scl_h = 1'b1; hp(); scl_h = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; hp(); scl_h = 1'b1;
    repeat (HP/2) @(negedge clk);
    b = sda_bus;
    repeat (HP/2) @(negedge clk);
    scl_h = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~ack_it);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    i2c_start();
    send_byte({DEV, 1'b0}, a1); send_byte(a, a2); send_byte(d, a3);
    i2c_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic rd_seq(input logic [7:0] a, input int n, output logic [39:0] got);
    logic k;
    logic [7:0] v;
    got = '0;
    i2c_start();
    send_byte({DEV, 1'b0}, k); send_byte(a, k);
    i2c_start();
    send_byte({DEV, 1'b1}, k);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, v);
      got[8*i +: 8] = v;
    end
    i2c_stop();
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    core_addr = a; @(negedge clk); v = core_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [7:0] v;
    logic [39:0] got;
    repeat (4) @(negedge clk);
    check("R10 sda released in reset", {39'h0, sda_oe}, 40'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    peek(8'h72, v); check("R10 reg reset", {32'h0, v}, 40'h0);
    check("R10 run low", {39'h0, run}, 40'h0);

    // table: write, observe at the core port, random read back
    for (int i = 0; i < 6; i++) begin
      wr_reg(VEC[i][15:8], VEC[i][7:0], ok);
      check("R1 write acked", {39'h0, ok}, 40'h1);
      peek(VEC[i][15:8], v);
      check("R2 core port", {32'h0, v}, {32'h0, VEC[i][7:0]});
      rd_seq(VEC[i][15:8], 1, got);
      check("R3 random read", got, {32'h0, VEC[i][7:0]});
    end
    check("R9 run level", {39'h0, run}, 40'h1);
    check("R9 cmd output", {32'h0, cmd}, 40'h3C);

    // R4 sequential write then sequential and current-address reads
    i2c_start();
    send_byte({DEV, 1'b0}, k); send_byte(8'h20, k);
    send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k);
    i2c_stop();
    rd_seq(8'h20, 3, got);
    check("R4 sequential read", got, 40'h332211);
    rd_seq(8'h20, 1, got);
    i2c_start(); send_byte({DEV, 1'b1}, k); recv_byte(1'b0, v); i2c_stop();
    check("R3 current-address read", {32'h0, v}, 40'h22);

    // R5 pointer wrap
    wr_reg(8'hFF, 8'h77, ok);
    rd_seq(8'hFF, 2, got);
    check("R5 wrap to 0x00", got, 40'hA577);

    // R1 foreign address
    i2c_start();
    send_byte({7'h44, 1'b0}, ok);
    check("R1 foreign addr not acked", {39'h0, ok}, 40'h0);
    send_byte(8'h30, k); send_byte(8'h99, k);
    i2c_stop();
    peek(8'h30, v); check("R1 foreign write ignored", {32'h0, v}, 40'h0);

    // R6 read-only window
    wr_reg(8'h5A, 8'hEE, ok);
    check("R6 window write acked", {39'h0, ok}, 40'h1);
    peek(8'h5A, v); check("R6 window unchanged", {32'h0, v}, 40'h0);

    // R7 request and load
    wr_reg(8'h14, 8'h01, ok);
    check("R7 request raised", {39'h0, anc_req}, 40'h1);
    anc_data = 40'h0504030201;
    anc_load = 1'b1; @(negedge clk); anc_load = 1'b0; @(negedge clk);
    check("R7 request cleared", {39'h0, anc_req}, 40'h0);
    rd_seq(8'h59, 5, got);
    check("R7 window contents", got, 40'h0504030201);

    // R8 soft reset
    wr_reg(8'h14, 8'h01, ok);
    srst_cycles = 0;
    wr_reg(8'h10, 8'hA7, ok);
    check("R8 soft reset pulse width", 40'(srst_cycles), 40'h1);
    check("R8 run cleared", {39'h0, run}, 40'h0);
    check("R8 request cleared", {39'h0, anc_req}, 40'h0);
    check("R8 cmd cleared", {32'h0, cmd}, 40'h0);
    peek(8'h40, v); check("R8 other reg kept", {32'h0, v}, 40'hFF);
    rd_seq(8'h10, 1, got);
    check("R8 reset reg reads zero", got, 40'h0);
    peek(8'h10, v); check("R6 reset reg not stored", {32'h0, v}, 40'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule